// File: doc/BRIEF.md
# Register-Programmed Memory Copy Engine

This block is a single-channel copy engine. A processor sets it up through four 32-bit registers: control/status, source base, destination base and transfer type. It then moves a number of elements from a source region to a destination region over a simple request/response bus master port. Each element is one read followed by one write, and only one access is outstanding at a time. The source and destination element sizes are chosen independently. A narrower element is zero-extended and a wider one is truncated to its low bits. Each address either steps by its element size or stays fixed.

A transfer starts in one of two ways. In the default mode, a register write to the transfer-type register starts it. In the event-driven mode, a rising edge on any of sixteen external event lines that is enabled in a mask starts it, using the transfer-type register already programmed.

The engine keeps these flags: busy, done, and separate sticky read-error and write-error flags. Any bus error ends the transfer at once. When the fence option is on, every error-free completion is followed by a one-cycle fence request.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, all control/status bits read as zero, no bus request is raised and the fence output is low.
- R2: With the control register at offset 0 having bit 0 (enable) set and bit 1 (event mode) clear, a write to the transfer-type register at offset 3 starts a transfer. While enable is clear, such a write starts nothing.
- R3: The transfer type holds the element count in bits [23:0], the source size in bits [25:24] and the destination size in bits [27:26], with sizes coded 00 byte, 01 half-word and 10 word. The source base is at offset 1 and the destination base at offset 2.
- R4: A source element is taken from the byte lanes selected by its address and zero-extended. The destination value is truncated to its size, replicated across the data bus, and written with byte enables set only for the lanes its address selects.
- R5: After each element, the source address advances by the source size when bit 28 is set and the destination address advances by the destination size when bit 29 is set. An address whose bit is clear stays fixed.
- R6: When event mode is set, a transfer starts on a rising edge of an event line whose bit is set in control bits [31:16]. Lines outside the mask, a level held high, and writes to the transfer type start nothing.
- R7: When control bit 2 is set, the fence output is high for exactly the one cycle after the final write response of an error-free transfer. It stays low after a transfer that ended in an error.
- R8: An error response to a read ends the transfer with no further access, sets control bit 10, and sets done.
- R9: An error response to a write ends the transfer with no further access, sets control bit 11, and sets done.
- R10: Control bit 8 (busy) is high while a transfer runs. Control bit 9 (done) is set when any transfer ends and stays set until the engine is disabled.
- R11: A start with an element count of zero makes no bus access, sets done, and raises the fence pulse when the fence option is on.
- R12: Writing control with bit 0 clear aborts any transfer, so the bus request drops on the next cycle, and clears busy, done and both error flags.
- R13: Starting a new transfer clears both error flags.
- R14: A bus request, with its address and direction held stable, stays raised until an acknowledge or error response. Each element's read precedes its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 source, 2 destination, 3 transfer type) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | input | 16 | External event lines |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 32 | Write data, replicated across lanes |
| bus_be | output | 4 | Byte enables for writes |
| bus_rdata | input | 32 | Read response data |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| fence_req | output | 1 | One-cycle fence request after a clean transfer |

## Verification
The copy is tried with these size pairings:
- word to word, which checks the plain copy and the address stepping;
- byte to word from an odd source, which separates correct lane extraction and zero-extension from a fixed lane;
- word to byte into an odd destination, which exposes truncation and byte-enable placement;
- half-word with a fixed source, which tells a held address from a stepping one.

Bus responses arrive with zero, one and two wait cycles, which shows whether request hold and read-before-write ordering depend on latency. Errors are injected on a read and on a write partway through a transfer, which separates the two sticky flags and checks that the fence is suppressed. Zero-count starts, event lines outside the mask, an event line held high, and a disable during a long-latency access cover starts that must do nothing and the abort path.

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [15:0]   irq,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic [3:0]    bus_be,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          fence_req
);
  localparam int CW = 24;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t          st;
  logic         en, auto_md, fence_en;
  logic [15:0]  mask, irq_q;
  logic [31:0]  src_base, dst_base, ttype;
  logic [AW-1:0] src_a, dst_a;
  logic [CW-1:0] left;
  logic [1:0]   ssz, dsz;
  logic         sinc, dinc;
  logic [31:0]  elem, rd_val, rd_sh;
  logic         done, rd_err, wr_err, fence_q;

  function automatic logic [2:0] step(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  wire ctrl_wr  = reg_wr && reg_addr == 2'd0;
  wire ttype_wr = reg_wr && reg_addr == 2'd3;
  wire kill     = ctrl_wr && !reg_wdata[0];
  wire idle     = st == S_IDLE;
  wire trig     = |(irq & mask & ~irq_q);
  wire start    = en && idle && (auto_md ? trig : ttype_wr);
  wire [CW-1:0] cfg_cnt = auto_md ? ttype[CW-1:0] : reg_wdata[CW-1:0];
  wire [5:0]    cfg_md  = auto_md ? ttype[29:24] : reg_wdata[29:24];
  wire [AW-1:0] src_inc = sinc ? {{(AW-3){1'b0}}, step(ssz)} : '0;
  wire [AW-1:0] dst_inc = dinc ? {{(AW-3){1'b0}}, step(dsz)} : '0;

  assign bus_req   = !idle;
  assign bus_we    = st == S_WR;
  assign bus_addr  = bus_we ? dst_a : src_a;
  assign fence_req = fence_q;
  assign rd_sh     = bus_rdata >> {src_a[1:0], 3'b000};

  always_comb begin
    case (ssz)
      2'd0:    rd_val = {24'd0, rd_sh[7:0]};
      2'd1:    rd_val = {16'd0, rd_sh[15:0]};
      default: rd_val = bus_rdata;
    endcase
    case (dsz)
      2'd0: begin
        bus_wdata = {4{elem[7:0]}};
        bus_be    = 4'b0001 << dst_a[1:0];
      end
      2'd1: begin
        bus_wdata = {2{elem[15:0]}};
        bus_be    = dst_a[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        bus_wdata = elem;
        bus_be    = 4'b1111;
      end
    endcase
    case (reg_addr)
      2'd0:    reg_rdata = {mask, 4'd0, wr_err, rd_err, done, !idle, 5'd0, fence_en, auto_md, en};
      2'd1:    reg_rdata = src_base;
      2'd2:    reg_rdata = dst_base;
      default: reg_rdata = ttype;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; auto_md <= 1'b0; fence_en <= 1'b0; mask <= '0;
      src_base <= '0; dst_base <= '0; ttype <= '0; irq_q <= '0;
    end else begin
      irq_q <= irq;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            en <= reg_wdata[0]; auto_md <= reg_wdata[1];
            fence_en <= reg_wdata[2]; mask <= reg_wdata[31:16];
          end
          2'd1:    src_base <= reg_wdata;
          2'd2:    dst_base <= reg_wdata;
          default: ttype <= reg_wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; src_a <= '0; dst_a <= '0; left <= '0; elem <= '0;
      ssz <= '0; dsz <= '0; sinc <= 1'b0; dinc <= 1'b0;
      done <= 1'b0; rd_err <= 1'b0; wr_err <= 1'b0; fence_q <= 1'b0;
    end else if (kill || !en) begin
      st <= S_IDLE;
      done <= 1'b0; rd_err <= 1'b0; wr_err <= 1'b0; fence_q <= 1'b0;
    end else begin
      fence_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd_err <= 1'b0;
          wr_err <= 1'b0;
          src_a  <= src_base[AW-1:0];
          dst_a  <= dst_base[AW-1:0];
          left   <= cfg_cnt;
          ssz    <= cfg_md[1:0];
          dsz    <= cfg_md[3:2];
          sinc   <= cfg_md[4];
          dinc   <= cfg_md[5];
          if (cfg_cnt == '0) begin
            done    <= 1'b1;
            fence_q <= fence_en;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (bus_err) begin
          rd_err <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else if (bus_ack) begin
          elem <= rd_val; st <= S_WR;
        end
        S_WR: if (bus_err) begin
          wr_err <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else if (bus_ack) begin
          src_a <= src_a + src_inc;
          dst_a <= dst_a + dst_inc;
          left  <= left - 24'd1;
          if (left == 24'd1) begin
            st <= S_IDLE; done <= 1'b1; fence_q <= fence_en;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          en,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          fence_req
);
  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err && !reg_wr |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_rd_then_wr_r14: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_ack && !bus_err && !reg_wr |=> bus_req && bus_we);

  p_rd_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_err |=> !bus_req);

  p_wr_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_err |=> !bus_req);

  p_no_fence_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> !fence_req);

  p_fence_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req |-> !bus_req);

  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !bus_req && !fence_req);
endmodule

bind dma_copy_engine dma_copy_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .en(en), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
  .fence_req(fence_req)
);

// File: tb/dma_copy_engine_tb.sv
module dma_copy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq = '0;
  logic        bus_req, bus_we, fence_req;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;

  dma_copy_engine #(.AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .fence_req(fence_req)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:63];
  logic [31:0] ref_mem [0:63];
  bit          q_we[$];
  logic [31:0] q_addr[$], q_wd[$];
  logic [3:0]  q_be[$];
  bit start_pend = 0, abort_pend = 0, zero_fence = 0, fence_pend = 0, m_fence = 0;
  bit err_arm = 0, err_we = 0;
  logic [31:0] err_addr = '0;
  int lat = 0, wait_cnt = 0, fence_seen = 0;
  logic [31:0] p_src = '0, p_dst = '0, p_cfg = '0;
  int p_cnt = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic int stepb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic plan_ops(logic [31:0] src, logic [31:0] dst, int cnt, logic [31:0] cfg);
    logic [31:0] sa = src, da = dst;
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] v, wd;
      logic [3:0] be;
      int n;
      v = ref_mem[sa[7:2]] >> (8 * sa[1:0]);
      if (cfg[25:24] == 2'd0) v = v & 32'hFF;
      else if (cfg[25:24] == 2'd1) v = v & 32'hFFFF;
      q_we.push_back(1'b0); q_addr.push_back(sa); q_wd.push_back('0); q_be.push_back('0);
      n = stepb(cfg[27:26]);
      wd = (n == 1) ? {4{v[7:0]}} : (n == 2) ? {2{v[15:0]}} : v;
      be = 4'((32'd1 << n) - 1) << da[1:0];
      q_we.push_back(1'b1); q_addr.push_back(da); q_wd.push_back(wd); q_be.push_back(be);
      for (int b = 0; b < 4; b++)
        if (be[b]) ref_mem[da[7:2]][8*b +: 8] = wd[8*b +: 8];
      if (cfg[28]) sa = sa + stepb(cfg[25:24]);
      if (cfg[29]) da = da + stepb(cfg[27:26]);
    end
  endtask

  task automatic clear_q();
    q_we.delete(); q_addr.delete(); q_wd.delete(); q_be.delete();
    wait_cnt = 0;
  endtask

  // kind: 0 plain, 1 starts a planned transfer, 2 aborts
  task automatic reg_write(logic [1:0] a, logic [31:0] d, int kind);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) m_fence = d[2];
    if (kind == 1) begin
      plan_ops(p_src, p_dst, p_cnt, p_cfg);
      start_pend = 1; zero_fence = (p_cnt == 0) && m_fence;
    end else if (kind == 2) begin
      abort_pend = 1;
    end
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic go_manual(logic [31:0] src, logic [31:0] dst, int cnt, logic [31:0] cfg);
    p_src = src; p_dst = dst; p_cnt = cnt; p_cfg = cfg;
    reg_write(2'd1, src, 0);
    reg_write(2'd2, dst, 0);
    reg_write(2'd3, {cfg[31:24], 24'(cnt)}, 1);
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((q_addr.size() != 0 || start_pend) && t < 5000) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic rd_ctrl(output logic [31:0] v);
    @(posedge clk); #1;
    v = reg_rdata;
  endtask

  task automatic mem_check(string req);
    for (int i = 0; i < 64; i++) chk(req, mem[i], ref_mem[i]);
  endtask

  task automatic resync();
    for (int i = 0; i < 64; i++) ref_mem[i] = mem[i];
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      chk("R14/R10 request vs model", 32'(bus_req), 32'(q_addr.size() != 0 && !start_pend));
      chk("R7 fence pulse", 32'(fence_req), 32'(fence_pend));
      if (fence_req) fence_seen++;
      fence_pend = 0;
      if (start_pend) begin
        start_pend = 0; fence_pend = zero_fence; zero_fence = 0;
      end else if (abort_pend) begin
        abort_pend = 0; clear_q();
      end else if (bus_req && q_addr.size() != 0) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          chk("R14 direction", 32'(bus_we), 32'(q_we[0]));
          chk("R5 address", bus_addr, q_addr[0]);
          if (q_we[0]) begin
            chk("R4 write data", bus_wdata, q_wd[0]);
            chk("R4 byte enables", 32'(bus_be), 32'(q_be[0]));
          end
          if (err_arm && bus_addr == err_addr && bus_we == err_we) begin
            bus_err = 1'b1; err_arm = 0; clear_q();
          end else begin
            bus_ack = 1'b1;
            if (bus_we) begin
              for (int b = 0; b < 4; b++)
                if (bus_be[b]) mem[bus_addr[7:2]][8*b +: 8] = bus_wdata[8*b +: 8];
            end else begin
              bus_rdata = mem[bus_addr[7:2]];
            end
            void'(q_we.pop_front()); void'(q_addr.pop_front());
            void'(q_wd.pop_front()); void'(q_be.pop_front());
            if (q_addr.size() == 0) fence_pend = m_fence;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int fs;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'hC3A5_0000 ^ (i * 32'h0103_0507);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_ctrl(v);
    chk("R1 control after reset", v, 32'h0);
    chk("R1 request after reset", 32'(bus_req), 32'h0);
    chk("R1 fence after reset", 32'(fence_req), 32'h0);

    // R2 disabled engine ignores the start write
    reg_write(2'd1, 32'h0, 0);
    reg_write(2'd2, 32'h80, 0);
    reg_write(2'd3, 32'h3A00_0003, 0);
    repeat (5) @(posedge clk);
    rd_ctrl(v);
    chk("R2 no start while disabled", v, 32'h0);
    mem_check("R2 memory untouched");

    // R2 R3 R5 R10 word copy
    reg_write(2'd0, 32'h1, 0);
    go_manual(32'h00, 32'h80, 4, 32'h3A00_0000);
    rd_ctrl(v);
    chk("R10 busy during transfer", v & 32'h300, 32'h100);
    wait_idle();
    rd_ctrl(v);
    chk("R10 done after transfer", v, 32'h201);
    mem_check("R3 word copy");

    // R4 byte to word, odd source, two wait cycles
    lat = 2;
    go_manual(32'h11, 32'hA0, 5, 32'h3800_0000);
    wait_idle();
    mem_check("R4 byte source");

    // R4 word to byte, odd destination
    lat = 1;
    go_manual(32'h20, 32'hC1, 3, 32'h3200_0000);
    wait_idle();
    mem_check("R4 byte destination");

    // R5 half-word, fixed source
    lat = 0;
    go_manual(32'h06, 32'hD0, 3, 32'h2500_0000);
    wait_idle();
    mem_check("R5 fixed source");

    // R7 fence after clean transfer
    reg_write(2'd0, 32'h5, 0);
    fs = fence_seen;
    go_manual(32'h30, 32'hE0, 2, 32'h3A00_0000);
    wait_idle();
    chk("R7 one fence pulse", 32'(fence_seen - fs), 32'd1);
    mem_check("R7 data");

    // R12 disable clears done
    reg_write(2'd0, 32'h0, 0);
    reg_write(2'd0, 32'h5, 0);
    rd_ctrl(v);
    chk("R12 flags cleared on disable", v, 32'h5);

    // R11 zero count
    fs = fence_seen;
    go_manual(32'h30, 32'hE0, 0, 32'h3A00_0000);
    wait_idle();
    rd_ctrl(v);
    chk("R11 done on zero count", v, 32'h205);
    chk("R11 fence on zero count", 32'(fence_seen - fs), 32'd1);

    // R8 read error on second element
    fs = fence_seen;
    err_arm = 1; err_we = 0; err_addr = 32'h44;
    go_manual(32'h40, 32'hF0, 3, 32'h3A00_0000);
    wait_idle();
    rd_ctrl(v);
    chk("R8 read error flag", v, 32'h605);
    chk("R7 no fence after error", 32'(fence_seen - fs), 32'd0);
    resync();

    // R13 new start clears the error
    go_manual(32'h50, 32'h90, 1, 32'h3A00_0000);
    wait_idle();
    rd_ctrl(v);
    chk("R13 error cleared by start", v, 32'h205);
    mem_check("R13 data");

    // R9 write error on second element
    err_arm = 1; err_we = 1; err_addr = 32'hB4;
    go_manual(32'h60, 32'hB0, 3, 32'h3A00_0000);
    wait_idle();
    rd_ctrl(v);
    chk("R9 write error flag", v, 32'hA05);
    resync();

    // R6 event-driven start
    reg_write(2'd0, 32'h0020_0003, 0);
    p_src = 32'h00; p_dst = 32'h40; p_cnt = 2; p_cfg = 32'h3A00_0000;
    reg_write(2'd1, p_src, 0);
    reg_write(2'd2, p_dst, 0);
    reg_write(2'd3, 32'h3A00_0002, 0);
    repeat (5) @(posedge clk);
    rd_ctrl(v);
    chk("R6 register write ignored in event mode", v, 32'h0020_0A03);
    @(posedge clk); #1 irq[3] = 1'b1;
    repeat (5) @(posedge clk);
    #1 irq[3] = 1'b0;
    rd_ctrl(v);
    chk("R6 unmasked line ignored", v, 32'h0020_0A03);
    @(posedge clk); #1;
    irq[5] = 1'b1;
    plan_ops(p_src, p_dst, p_cnt, p_cfg);
    start_pend = 1; zero_fence = 0;
    wait_idle();
    repeat (20) @(posedge clk);
    #1 irq[5] = 1'b0;
    rd_ctrl(v);
    chk("R6 event transfer done, R13 error cleared", v, 32'h0020_0203);
    mem_check("R6 data");

    // R12 abort during a long access
    reg_write(2'd0, 32'h1, 0);
    lat = 60;
    go_manual(32'h00, 32'h60, 4, 32'h3A00_0000);
    repeat (5) @(posedge clk);
    reg_write(2'd0, 32'h0, 2);
    repeat (3) @(posedge clk);
    rd_ctrl(v);
    chk("R12 abort clears state", v, 32'h0);
    chk("R12 request dropped", 32'(bus_req), 32'h0);
    resync();
    lat = 0;

    repeat (5) @(posedge clk);
    summary();
  end
endmodule